// File: doc/BRIEF.md
# Strobed Parallel Input Port

This block is a small processor peripheral that brings one 8-bit word in from an external device. On the processor side it has an active-low select, an active-low read strobe, an active-low write strobe and one address line. It also has an active-high reset, an interrupt request output and an 8-bit bidirectional three-state data bus. On the device side it takes an 8-bit input word, an active-low strobe from the device and a buffer-full flag back to the device.

The address line gives the bus an asymmetric view. With address 0, a read returns the input data, and that location cannot be written. With address 1, a write loads the control register and a read returns the status register. Control bit 0 picks the mode. Mode 0 passes the live input word straight through to a read. Mode 1 captures the word on the device strobe, raises buffer full, and can raise an interrupt once the strobe ends. Control bit 1 enables that interrupt. Status bit 0 is buffer full, bit 1 is the interrupt enable and bit 2 is the interrupt request. In mode 0 the status register reads as zero.

The block runs on one system clock. The strobe, read and write pins pass through synchronizers, and the block acts on their edges.

Top module: `spio_port`

## Requirements
- R1: While reset is high, the control bits, buffer full and the interrupt request are cleared to 0, so after reset a status read returns 8'h00.
- R2: The block drives the data bus only while select and read are both low. At all other times the bus is high impedance, including when read is low with select high.
- R3: When the write strobe falls with select low and address 1, the bus value is loaded into control (bit 0 = mode, bit 1 = interrupt enable). A write with select high leaves control unchanged.
- R4: In mode 0, a read with address 0 returns the live input word.
- R5: In mode 0, a status read returns 8'h00 and buffer full and the interrupt request stay 0, whatever the strobe and the enable bit do.
- R6: In mode 1, a falling edge of the device strobe captures the input word and sets buffer full. Later changes on the input word do not change the value a data read returns.
- R7: In mode 1, a status read returns {5'b0, interrupt request, interrupt enable, buffer full}.
- R8: In mode 1, the rising edge of the device strobe sets the interrupt request only when buffer full and interrupt enable are both 1.
- R9: The falling read strobe of a data read (select low, address 0) clears the interrupt request. Buffer full clears when that read strobe returns high.
- R10: A status read changes neither buffer full nor the interrupt request.
- R11: Any control write clears buffer full and the interrupt request.
- R12: A write with address 0 does not change the captured data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_bus | inout | 8 | Three-state processor data bus |
| intr | output | 1 | Interrupt request |
| port_in | input | 8 | Input word from the device |
| stb_n | input | 1 | Device strobe, active low |
| ibf | output | 1 | Input buffer full |

## Verification
The hardest case to reach is a second device strobe that arrives while buffer full is still set. With the enable bit on and a data read pending, it can overwrite the captured word and raise the interrupt again. This can also coincide with a mode change that must clear everything. Random sequences of control writes, strobes with changing data, status reads, data reads and ignored writes reach these overlaps. The random order is mixed with directed runs that set the enable bit and strobe twice before reading. A reference model in the bench tracks mode, enable, buffer full, interrupt and the captured word. It predicts every read and every flag.

// File: rtl/spio_pkg.sv
package spio_pkg;
  localparam int DW       = 8;
  localparam int SYNC_N   = 2;
  localparam int MODE_POS = 0;
  localparam int INTE_POS = 1;
  localparam int ST_IBF   = 0;
  localparam int ST_INTE  = 1;
  localparam int ST_INTR  = 2;

  typedef logic [DW-1:0] word_t;

  typedef struct packed {
    logic inte;
    logic mode;
  } ctl_t;

  // Status layout; in the unlatched mode the register is absent and reads zero.
  function automatic word_t status_word(input ctl_t c, input logic full, input logic irq);
    word_t w;
    w = '0;
    if (c.mode) begin
      w[ST_IBF]  = full;
      w[ST_INTE] = c.inte;
      w[ST_INTR] = irq;
    end
    return w;
  endfunction

  // Value presented on the bus for a read at the given address.
  function automatic word_t read_word(input logic adr, input ctl_t c, input word_t held,
                                      input word_t live, input logic full, input logic irq);
    if (adr) return status_word(c, full, irq);
    return c.mode ? held : live;
  endfunction
endpackage

// File: rtl/spio_sync.sv
module spio_sync #(
  parameter int   W      = 1,
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= {STAGES*W{IDLE}};
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= {STAGES*W{IDLE}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prev <= {W{IDLE}};
    else     prev <= chain[STAGES-1];
  end

  assign q    = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
  assign rise = ~prev & chain[STAGES-1];
endmodule

// File: rtl/spio_busif.sv
module spio_busif (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic a0,
  input  logic rd_n,
  input  logic rd_fall,
  input  logic rd_rise,
  input  logic wr_fall,
  output logic wr_ctl,
  output logic rd_dat_start,
  output logic rd_dat_end,
  output logic bus_oe
);
  logic sel;
  logic rd_dat_q;

  assign sel          = ~ce_n;
  assign bus_oe       = sel & ~rd_n;
  assign wr_ctl       = wr_fall & sel & a0;
  assign rd_dat_start = rd_fall & sel & ~a0;
  assign rd_dat_end   = rd_rise & rd_dat_q;

  // Remembers that the open read cycle targets the data register.
  always_ff @(posedge clk or posedge rst) begin
    if (rst)               rd_dat_q <= 1'b0;
    else if (rd_dat_start) rd_dat_q <= 1'b1;
    else if (rd_rise)      rd_dat_q <= 1'b0;
  end
endmodule

// File: rtl/spio_inport.sv
module spio_inport
  import spio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  word_t port_in,
  input  word_t wdata,
  input  logic  wr_ctl,
  input  logic  stb_fall,
  input  logic  stb_rise,
  input  logic  rd_dat_start,
  input  logic  rd_dat_end,
  output ctl_t  ctl,
  output word_t held,
  output logic  full,
  output logic  irq
);
  logic  spare_unused;
  ctl_t  ctl_next;
  logic  capture;
  logic  raise_irq;

  assign spare_unused   = ^wdata;
  assign ctl_next.mode  = wdata[MODE_POS];
  assign ctl_next.inte  = wdata[INTE_POS];
  assign capture        = ctl.mode & stb_fall;
  assign raise_irq      = ctl.mode & ctl.inte & full & stb_rise;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)         ctl <= '0;
    else if (wr_ctl) ctl <= ctl_next;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          held <= '0;
    else if (capture) held <= port_in;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             full <= 1'b0;
    else if (wr_ctl)     full <= 1'b0;
    else if (capture)    full <= 1'b1;
    else if (rd_dat_end) full <= 1'b0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               irq <= 1'b0;
    else if (wr_ctl)       irq <= 1'b0;
    else if (rd_dat_start) irq <= 1'b0;
    else if (raise_irq)    irq <= 1'b1;
  end
endmodule

// File: rtl/spio_port.sv
module spio_port
  import spio_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          a0,
  input  logic          rd_n,
  input  logic          wr_n,
  inout  wire  [DW-1:0] data_bus,
  output logic          intr,
  input  logic [DW-1:0] port_in,
  input  logic          stb_n,
  output logic          ibf
);
  localparam int NSIG = 3;
  localparam int I_STB = 0;
  localparam int I_RD  = 1;
  localparam int I_WR  = 2;

  logic [NSIG-1:0] raw_v, lvl_unused, fall_v, rise_v;
  logic  stb_fall, stb_rise, rd_fall, rd_rise, wr_fall, wr_rise_unused;
  logic  wr_ctl, rd_dat_start, rd_dat_end, bus_oe;
  ctl_t  ctl;
  word_t held, rdata;
  logic  full, irq;

  assign raw_v[I_STB] = stb_n;
  assign raw_v[I_RD]  = rd_n;
  assign raw_v[I_WR]  = wr_n;

  spio_sync #(.W(NSIG), .STAGES(SYNC_N), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(lvl_unused), .fall(fall_v), .rise(rise_v)
  );

  assign stb_fall       = fall_v[I_STB];
  assign stb_rise       = rise_v[I_STB];
  assign rd_fall        = fall_v[I_RD];
  assign rd_rise        = rise_v[I_RD];
  assign wr_fall        = fall_v[I_WR];
  assign wr_rise_unused = rise_v[I_WR];

  spio_busif u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .a0(a0), .rd_n(rd_n),
    .rd_fall(rd_fall), .rd_rise(rd_rise), .wr_fall(wr_fall),
    .wr_ctl(wr_ctl), .rd_dat_start(rd_dat_start), .rd_dat_end(rd_dat_end), .bus_oe(bus_oe)
  );

  spio_inport u_in (
    .clk(clk), .rst(rst), .port_in(port_in), .wdata(data_bus), .wr_ctl(wr_ctl),
    .stb_fall(stb_fall), .stb_rise(stb_rise), .rd_dat_start(rd_dat_start),
    .rd_dat_end(rd_dat_end), .ctl(ctl), .held(held), .full(full), .irq(irq)
  );

  assign rdata    = read_word(a0, ctl, held, port_in, full, irq);
  assign data_bus = bus_oe ? rdata : {DW{1'bz}};
  assign intr     = irq;
  assign ibf      = full;
endmodule

// File: rtl/spio_chk.sv
module spio_chk
  import spio_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  intr,
  input logic  ibf,
  input ctl_t  ctl,
  input word_t held,
  input logic  stb_fall,
  input logic  stb_rise,
  input logic  rd_dat_end,
  input logic  wr_ctl
);
  AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctl.mode |-> (!ibf && !intr)); // R5
  AST_IBF_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(ibf) |-> $past(stb_fall)); // R6
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(stb_fall) |-> $stable(held)); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(intr) |-> ($past(stb_rise) && $past(ibf) && $past(ctl.inte))); // R8
  AST_IRQ_NEEDS_INTE: assert property (@(posedge clk) disable iff (rst)
    intr |-> ctl.inte); // R8
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(ibf) |-> ($past(rd_dat_end) || $past(wr_ctl))); // R9
  AST_CTL_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (!ibf && !intr)); // R11
endmodule

bind spio_port spio_chk u_chk (
  .clk(clk), .rst(rst), .intr(intr), .ibf(ibf), .ctl(ctl), .held(held),
  .stb_fall(stb_fall), .stb_rise(stb_rise), .rd_dat_end(rd_dat_end), .wr_ctl(wr_ctl)
);

// File: tb/spio_port_tb.sv
module spio_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1, stb_n = 1'b1;
  logic [7:0] port_in = 8'h00;
  logic       tb_oe = 1'b0;
  logic [7:0] tb_dout = 8'h00;
  wire  [7:0] data_bus;
  logic       intr, ibf;

  int vectors = 0;
  int fails = 0;

  // reference state
  logic       m_mode = 0, m_inte = 0, m_ibf = 0, m_intr = 0;
  logic [7:0] m_held = 8'h00;

  assign data_bus = tb_oe ? tb_dout : 8'bzzzzzzzz;

  always #5 clk = ~clk;

  spio_port u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n),
    .data_bus(data_bus), .intr(intr), .port_in(port_in), .stb_n(stb_n), .ibf(ibf)
  );

  function automatic logic [7:0] exp_status();
    return m_mode ? {5'b0, m_intr, m_inte, m_ibf} : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag);
    chk({tag, " ibf"}, {7'b0, ibf}, {7'b0, m_ibf});
    chk({tag, " intr"}, {7'b0, intr}, {7'b0, m_intr});
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic ce_lo, input logic adr, input logic [7:0] v);
    @(negedge clk);
    ce_n = ~ce_lo; a0 = adr; tb_dout = v; tb_oe = 1'b1;
    wait_n(1); wr_n = 1'b0;
    wait_n(5); wr_n = 1'b1;
    wait_n(5); ce_n = 1'b1; tb_oe = 1'b0;
    wait_n(2);
    if (ce_lo && adr) begin
      m_mode = v[0]; m_inte = v[1]; m_ibf = 1'b0; m_intr = 1'b0;
    end
  endtask

  task automatic do_read(input logic adr, input string tag);
    logic [7:0] e;
    @(negedge clk);
    ce_n = 1'b0; a0 = adr;
    wait_n(1); rd_n = 1'b0;
    e = adr ? exp_status() : (m_mode ? m_held : port_in);
    wait_n(5);
    chk(tag, data_bus, e);
    if (!adr) m_intr = 1'b0;
    chk({tag, " intr during read R9"}, {7'b0, intr}, {7'b0, m_intr});
    rd_n = 1'b1;
    wait_n(5);
    if (!adr) m_ibf = 1'b0;
    ce_n = 1'b1;
    wait_n(2);
    chk_flags({tag, " after read"});
  endtask

  task automatic do_strobe(input logic [7:0] d, input logic [7:0] junk);
    @(negedge clk);
    port_in = d;
    wait_n(1); stb_n = 1'b0;
    wait_n(5);
    if (m_mode) begin m_held = d; m_ibf = 1'b1; end
    chk_flags("R6 strobe low");
    port_in = junk;
    stb_n = 1'b1;
    wait_n(5);
    if (m_mode && m_ibf && m_inte) m_intr = 1'b1;
    chk_flags("R8 strobe high");
  endtask

  task automatic chk_float(input string tag);
    chk(tag, data_bus, 8'bzzzzzzzz);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int seed_ret;
    seed_ret = $urandom(32'h1357);
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    chk_flags("R1 reset");
    chk_float("R2 idle bus after reset");
    do_read(1'b1, "R1 status after reset");

    // R2 read low with select high must float
    @(negedge clk); rd_n = 1'b0; wait_n(5);
    chk_float("R2 read without select");
    rd_n = 1'b1; wait_n(5);

    // R4 mode 0 live read
    port_in = 8'h5A;
    do_read(1'b0, "R4 mode0 live");
    port_in = 8'hC3;
    do_read(1'b0, "R4 mode0 live 2");

    // R3 write with select high ignored; R5 status zero in mode 0
    do_write(1'b0, 1'b1, 8'h03);
    do_read(1'b1, "R3 ignored write");
    do_write(1'b1, 1'b1, 8'h02);
    do_read(1'b1, "R5 mode0 status");
    do_strobe(8'h11, 8'h22);
    chk_flags("R5 mode0 strobe");

    // R7 mode 1 with interrupt enabled
    do_write(1'b1, 1'b1, 8'h03);
    do_read(1'b1, "R7 status mode1");
    do_strobe(8'hA5, 8'h0F);
    do_read(1'b1, "R10 status keeps flags");
    do_write(1'b1, 1'b0, 8'h3C);
    do_read(1'b1, "R12 status after a0=0 write");
    do_strobe(8'h96, 8'h00);
    do_read(1'b0, "R6 R12 held data");

    // R8 no interrupt without enable
    do_write(1'b1, 1'b1, 8'h01);
    do_strobe(8'h77, 8'h88);
    do_read(1'b1, "R8 no inte status");

    // R11 control write clears flags
    do_write(1'b1, 1'b1, 8'h03);
    do_strobe(8'hE1, 8'h1E);
    do_write(1'b1, 1'b1, 8'h03);
    chk_flags("R11 ctl write clears");
    do_read(1'b1, "R11 status");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: do_write(($urandom_range(0, 3) != 0), 1'b1, 8'($urandom));
        1, 2: do_strobe(8'($urandom), 8'($urandom));
        3: do_read(1'b0, "R9 random data read");
        4: do_read(1'b1, "R7 random status read");
        5: do_write(1'b1, 1'b0, 8'($urandom));
        default: begin
          port_in = 8'($urandom);
          chk_float("R2 random idle");
          chk_flags("R10 random idle");
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule